// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gating Controller

This block sits between a host's active-low chip-enable and a group of external SRAM chip-enable outputs. While the supply is healthy, it routes the host enable to one output, chosen by a bank select code, and holds every other output inactive. An external comparator raises a digital power-fail flag. Once that flag is seen, the block accepts no new access. An access that is already running may finish, but only within a write-protect timeout. After that every output is forced inactive.

When the flag drops again, the outputs stay blocked for a settling hold period. This gives the host time to stabilise before memory can be touched. Reset enters the same hold, so memory cannot be enabled until one full hold period has passed after power-up.

A strap input picks one of two detection thresholds. The block passes that choice on to the comparator as a two-bit code. The host enable and the power-fail flag each pass through a two-flop synchroniser. The gated outputs are registered. An input change therefore reaches the outputs three clock edges later.

Top module: `pf_ce_gate`

## Requirements
- R1: When no power-fail is in effect, the output whose index equals `bank_sel` (0 selects `mem_ce_n[0]` through 3 selects `mem_ce_n[3]`) follows `host_ce_n`, and all other outputs stay high.
- R2: When power-fail is detected while the host enable is high, all outputs go high and stay high, even if the host enable is later driven low.
- R3: When power-fail is detected while the host enable is low, the selected output stays low until the host enable returns high. From then on, all outputs are high.
- R4: When an access held open by R3 lasts `WPT_CYC` clock cycles without ending, all outputs are forced high, even though the host enable is still low.
- R5: After the power-fail flag drops, all outputs stay high for `HOLD_CYC` clock cycles. After that, R1 behaviour resumes.
- R6: While reset is asserted, all outputs are high. After reset is released they stay high for a full `HOLD_CYC` hold period.
- R7: When power-fail reasserts during the hold period, the hold is abandoned. A full `HOLD_CYC` period restarts only once the flag drops again.
- R8: `thr_code` is 2'b01 when `thr_sel` is 0 and 2'b10 when `thr_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_ce_n | input | 1 | Host chip-enable, active low, asynchronous to clk |
| bank_sel | input | 2 | Index of the output that follows the host enable |
| pwr_fail | input | 1 | Power-fail flag from the external comparator, active high, asynchronous |
| thr_sel | input | 1 | Threshold-select strap |
| mem_ce_n | output | 4 | Conditioned active-low chip-enables to the SRAMs |
| thr_code | output | 2 | Threshold select code to the comparator |

## Verification
The hardest situation to reach is a power-fail that reasserts partway through the recovery hold. Whether the counter restarted cannot be seen at once, because the outputs are high in both cases. The stimulus first builds up part of a hold period and then pulses the flag. It then waits for a total time longer than one hold period but shorter than the remaining time after a restart, and checks that the outputs are still blocked. The timeout case is reached by holding the host enable low across a power-fail and sampling on both sides of the `WPT_CYC` boundary.

// File: rtl/pf_ce_pkg.sv
package pf_ce_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } gate_state_t;

  // Outputs may track the host only in these states
  function automatic logic gate_open(input gate_state_t st);
    return (st == ST_NORMAL) || (st == ST_DRAIN);
  endfunction

endpackage

// File: rtl/pfg_rst_sync.sv
module pfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
  import pf_ce_pkg::*;
#(
  parameter int WPT_CYC  = 500,
  parameter int HOLD_CYC = 6000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pf_s,
  input  logic ce_act,
  output logic open_nxt
);

  localparam int MAX_CYC   = (WPT_CYC > HOLD_CYC) ? WPT_CYC : HOLD_CYC;
  localparam int CNT_W     = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] WPT_LAST  = CNT_W'(WPT_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  gate_state_t      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             st_en, cnt_en;

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_NORMAL: begin
        if (pf_s) begin
          st_d  = ce_act ? ST_DRAIN : ST_PROTECT;
          cnt_d = '0;
        end
      end
      ST_DRAIN: begin
        if (!ce_act || (cnt_q == WPT_LAST)) begin
          st_d  = ST_PROTECT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_PROTECT: begin
        if (!pf_s) begin
          st_d  = ST_RECOVER;
          cnt_d = '0;
        end
      end
      ST_RECOVER: begin
        if (pf_s) begin
          st_d  = ST_PROTECT;
          cnt_d = '0;
        end else if (cnt_q == HOLD_LAST) begin
          st_d  = ST_NORMAL;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        st_d  = ST_PROTECT;
        cnt_d = '0;
      end
    endcase
  end

  assign st_en  = (st_d != st_q);
  assign cnt_en = (cnt_d != cnt_q);

  // State and counter registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_RECOVER;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign open_nxt = gate_open(st_d);

  // Independent dwell counters for the checks below
  logic [CNT_W-1:0] drain_age_q, rec_age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_age_q <= '0;
      rec_age_q   <= '0;
    end else begin
      drain_age_q <= (st_d == ST_DRAIN   && st_q == ST_DRAIN)   ? drain_age_q + CNT_W'(1) : '0;
      rec_age_q   <= (st_d == ST_RECOVER && st_q == ST_RECOVER) ? rec_age_q + CNT_W'(1)   : '0;
    end
  end

  // R4
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN) |-> (drain_age_q <= WPT_LAST));

  // R5
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORMAL && $past(st_q) == ST_RECOVER) |-> ($past(rec_age_q) == HOLD_LAST));

  // R7
  recover_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECOVER && pf_s) |=> (st_q == ST_PROTECT));

  // R5
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORMAL && $past(st_q) != ST_NORMAL) |-> ($past(st_q) == ST_RECOVER));

endmodule

// File: rtl/pfg_steer.sv
module pfg_steer #(
  parameter int N_OUT = 4,
  localparam int SEL_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_nxt,
  input  logic             ce_act,
  input  logic [SEL_W-1:0] bank_sel,
  output logic [N_OUT-1:0] ce_n_q
);

  logic [N_OUT-1:0] hit;

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      assign hit[i] = open_nxt & ce_act & (bank_sel == SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_n_q[i] <= 1'b1;
        else        ce_n_q[i] <= ~hit[i];
      end
    end
  endgenerate

  // R1
  single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n_q));

endmodule

// File: rtl/pf_ce_gate.sv
module pf_ce_gate #(
  parameter int N_OUT    = 4,
  parameter int WPT_CYC  = 500,
  parameter int HOLD_CYC = 6000000,
  localparam int SEL_W   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_ce_n,
  input  logic [SEL_W-1:0] bank_sel,
  input  logic             pwr_fail,
  input  logic             thr_sel,
  output logic [N_OUT-1:0] mem_ce_n,
  output logic [1:0]       thr_code
);

  logic rst_i;
  logic ce_s_n;
  logic pf_s;
  logic open_nxt;

  pfg_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_i)
  );

  pfg_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_ce_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     (host_ce_n),
    .q     (ce_s_n)
  );

  pfg_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_pf_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     (pwr_fail),
    .q     (pf_s)
  );

  pfg_ctrl #(.WPT_CYC(WPT_CYC), .HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i),
    .pf_s     (pf_s),
    .ce_act   (~ce_s_n),
    .open_nxt (open_nxt)
  );

  pfg_steer #(.N_OUT(N_OUT)) u_steer (
    .clk      (clk),
    .rst_n    (rst_i),
    .open_nxt (open_nxt),
    .ce_act   (~ce_s_n),
    .bank_sel (bank_sel),
    .ce_n_q   (mem_ce_n)
  );

  // Threshold strap forwarded as a one-hot level code
  assign thr_code = thr_sel ? 2'b10 : 2'b01;

  // R2
  idle_fail_block_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (pf_s && ce_s_n) |=> (&mem_ce_n));

  // R8
  thr_code_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (thr_code[1] == thr_sel) && (thr_code[0] == !thr_sel));

endmodule

// File: tb/pf_ce_gate_test.sv
module pf_ce_gate_test;

  localparam int WPT  = 16;
  localparam int HOLD = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_ce_n;
  logic [1:0] bank_sel;
  logic       pwr_fail;
  logic       thr_sel;
  logic [3:0] mem_ce_n;
  logic [1:0] thr_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pf_ce_gate #(.N_OUT(4), .WPT_CYC(WPT), .HOLD_CYC(HOLD)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_ce_n (host_ce_n),
    .bank_sel  (bank_sel),
    .pwr_fail  (pwr_fail),
    .thr_sel   (thr_sel),
    .mem_ce_n  (mem_ce_n),
    .thr_code  (thr_code)
  );

  // {host_ce_n, bank_sel[1:0], expected mem_ce_n[3:0]} with supply good
  localparam logic [6:0] VEC [0:7] = '{
    {1'b0, 2'd0, 4'b1110},
    {1'b0, 2'd3, 4'b0111},
    {1'b1, 2'd3, 4'b1111},
    {1'b0, 2'd1, 4'b1101},
    {1'b0, 2'd2, 4'b1011},
    {1'b1, 2'd0, 4'b1111},
    {1'b0, 2'd2, 4'b1011},
    {1'b1, 2'd1, 4'b1111}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_ce(input logic [3:0] exp, input string req);
    checks++;
    if (mem_ce_n !== exp) begin
      errors++;
      $display("FAIL %s: mem_ce_n=%b expected %b", req, mem_ce_n, exp);
    end
  endtask

  task automatic chk_thr(input logic [1:0] exp, input string req);
    checks++;
    if (thr_code !== exp) begin
      errors++;
      $display("FAIL %s: thr_code=%b expected %b", req, thr_code, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    host_ce_n = 1'b0;
    bank_sel  = 2'd0;
    pwr_fail  = 1'b0;
    thr_sel   = 1'b0;
    wait_cyc(4);
    // R6: outputs high in reset even with host enable low
    chk_ce(4'b1111, "R6");
    // R8: low threshold code
    chk_thr(2'b01, "R8");
    thr_sel = 1'b1;
    #1;
    chk_thr(2'b10, "R8");
    thr_sel = 1'b0;

    rst_n = 1'b1;
    wait_cyc(30);
    // R6: still within hold after reset release
    chk_ce(4'b1111, "R6");
    wait_cyc(20);
    chk_ce(4'b1110, "R6");

    // R1: table of normal-mode routing
    for (int k = 0; k < 8; k++) begin
      host_ce_n = VEC[k][6];
      bank_sel  = VEC[k][5:4];
      wait_cyc(4);
      chk_ce(VEC[k][3:0], "R1");
    end

    // R3: access in progress drains
    host_ce_n = 1'b0;
    bank_sel  = 2'd2;
    wait_cyc(4);
    chk_ce(4'b1011, "R1");
    pwr_fail = 1'b1;
    wait_cyc(4);
    chk_ce(4'b1011, "R3");
    host_ce_n = 1'b1;
    wait_cyc(4);
    chk_ce(4'b1111, "R3");
    // R2: new access blocked during power-fail
    host_ce_n = 1'b0;
    wait_cyc(4);
    chk_ce(4'b1111, "R2");
    // R5: hold after recovery
    pwr_fail = 1'b0;
    wait_cyc(20);
    chk_ce(4'b1111, "R5");
    wait_cyc(30);
    chk_ce(4'b1011, "R5");

    // R2: fail while idle, then enable low
    host_ce_n = 1'b1;
    wait_cyc(4);
    pwr_fail = 1'b1;
    wait_cyc(4);
    host_ce_n = 1'b0;
    wait_cyc(6);
    chk_ce(4'b1111, "R2");
    pwr_fail = 1'b0;
    wait_cyc(50);
    chk_ce(4'b1011, "R5");

    // R4: write-protect timeout
    bank_sel = 2'd1;
    wait_cyc(4);
    chk_ce(4'b1101, "R1");
    pwr_fail = 1'b1;
    wait_cyc(8);
    chk_ce(4'b1101, "R4");
    wait_cyc(14);
    chk_ce(4'b1111, "R4");
    pwr_fail = 1'b0;
    wait_cyc(4);
    chk_ce(4'b1111, "R5");

    // R7: power-fail pulse during hold restarts it
    wait_cyc(16);
    pwr_fail = 1'b1;
    wait_cyc(4);
    chk_ce(4'b1111, "R7");
    pwr_fail = 1'b0;
    wait_cyc(30);
    chk_ce(4'b1111, "R7");
    wait_cyc(20);
    chk_ce(4'b1101, "R7");

    // R6: reset mid-operation forces outputs high at once
    rst_n = 1'b0;
    #1;
    chk_ce(4'b1111, "R6");
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(20);
    chk_ce(4'b1111, "R6");
    wait_cyc(30);
    chk_ce(4'b1101, "R6");

    finish_run();
  end

endmodule